// File: doc/BRIEF.md
# Overlap-Safe Rectangle Fill and Copy Engine

This block is a register-programmed drawing engine that works on a linear pixel memory. It performs two operations: painting a solid rectangle with a stored colour, and copying one rectangle of pixels onto another. The copy walks its addresses in whichever horizontal and vertical order software selects, so a copy whose source and destination overlap still produces the right picture. Every pixel address is `x + y * pitch`, and the engine touches at most one pixel per clock.

Software sends 32-bit register writes over a simple write bus. Each write enters a small in-order queue. Queued writes are applied only while no operation is running. Writing the control word at offset 0x000 only stores it. Writing the same word at offset 0x100 stores it and starts the operation that it encodes. Two read-only registers report the engine state: 0x200 carries the busy flag, and 0x204 carries the number of free queue entries.

Register offsets are byte addresses on `bus_addr`:
- 0x000 control
- 0x100 control with start
- 0x004 colour
- 0x008 fill left
- 0x00C fill right
- 0x010 fill top row
- 0x014 fill row count
- 0x018 scan sign
- 0x01C row step
- 0x020 source start
- 0x028 destination x bounds
- 0x02C destination row/count
- 0x030 pitch

Writes to any other offset are accepted into the queue and have no effect. `FIFO_DEPTH` must be a power of two, and `ADDR_W` may be at most 29.

Top module: `blit2d_engine`

## Requirements
- R1: After reset, bit 16 of the status register (0x200) reads 0, the free-entry register (0x204) reads FIFO_DEPTH in its low 8 bits, and no memory read or write is issued.
- R2: The control word has the opcode in bits 3:0 (0x4 = fill, 0x8 = copy), and bit 19 must be set to select the replace operation. A write to 0x000 stores the word and starts nothing. A write to 0x100 stores the word and starts the operation. Any other opcode, or bit 19 clear, ends the operation without any memory access.
- R3: Status bit 16 reads 1 while any queued write is pending, an operation is running, or a copy write is still outstanding. It reads 0 otherwise, and memory is accessed only while it reads 1.
- R4: The free-entry register equals FIFO_DEPTH minus the number of pending writes. Pending writes are applied strictly in arrival order, and only while no operation is active. A write that arrives while the queue is full is discarded.
- R5: A fill writes the low PIX_W bits of the colour register to every pixel with left <= x < right and top <= y < top + rows. Pixels are written left to right within a row and rows top to bottom, one pixel per cycle. If right <= left, or rows = 0, nothing is written.
- R6: A copy takes its destination left edge from bits 15:0 of 0x028 and its inclusive right edge from bits 31:16. It takes its first destination row from bits 31:16 of 0x02C and its row count from bits 15:0. The copy width is right - left + 1. A row count of 0, or right < left, performs no memory access.
- R7: When bit 0 of the scan-sign register is set, source and destination addresses both decrease by 1 per pixel, and the destination row begins at the right edge. Otherwise they increase by 1 from the left edge. Bit 2 is accepted without effect.
- R8: The source row begins at the source-start register. After each row, both the source and destination row addresses add the row-step register, read as a two's complement number modulo 2^ADDR_W.
- R9: During a copy, each pixel is read one cycle before it is written, and the written value is the value read. As a result, an overlapping copy scanned away from the overlap produces the source picture at the destination.
- R10: Only the low 13 bits of the pitch register are used. All addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 14 | Register byte offset for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the status registers, combinational from bus_addr |
| mem_rd_en | output | 1 | Pixel read request |
| mem_rd_addr | output | ADDR_W | Pixel read address |
| mem_rd_data | input | PIX_W | Read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Pixel write strobe |
| mem_wr_addr | output | ADDR_W | Pixel write address |
| mem_wr_data | output | PIX_W | Pixel write data |

## Verification
A write captured at a clock edge changes the free count and the busy flag right after that edge, and the bench reads both registers at the following falling edge. A start write is taken from the queue one cycle after it is captured, and the parameters are latched in the cycle after that. The first pixel write of a fill therefore falls in the third cycle, and each copy write falls one cycle after its read. Because those delays are fixed but tedious to count for every rectangle, the driver pushes the full ordered list of expected address/data pairs before each start. A monitor compares every write strobe against the head of that list as it appears, and flags any write that arrives with the list empty. Busy is then polled to zero, and the list must be empty at that point, so missing writes, extra writes and writes out of order are all caught.

// File: rtl/blit2d_engine.sv
module blit2d_engine #(
  parameter int ADDR_W     = 20,
  parameter int PIX_W      = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [13:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [PIX_W-1:0]  mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [PIX_W-1:0]  mem_wr_data
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  localparam logic [13:0] A_CTRL  = 14'h000;
  localparam logic [13:0] A_GO    = 14'h100;
  localparam logic [13:0] A_COLOR = 14'h004;
  localparam logic [13:0] A_FL    = 14'h008;
  localparam logic [13:0] A_FR    = 14'h00C;
  localparam logic [13:0] A_FY    = 14'h010;
  localparam logic [13:0] A_FH    = 14'h014;
  localparam logic [13:0] A_SIGN  = 14'h018;
  localparam logic [13:0] A_STEP  = 14'h01C;
  localparam logic [13:0] A_SRC   = 14'h020;
  localparam logic [13:0] A_DXB   = 14'h028;
  localparam logic [13:0] A_DYL   = 14'h02C;
  localparam logic [13:0] A_PITCH = 14'h030;
  localparam logic [13:0] A_STAT  = 14'h200;
  localparam logic [13:0] A_FREE  = 14'h204;

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_RUN} state_t;
  state_t st;

  logic [13:0]      q_addr [FIFO_DEPTH];
  logic [31:0]      q_data [FIFO_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] used;
  logic             wpend;

  wire full  = (used == DEPTH_C);
  wire empty = (used == '0);
  wire push  = bus_wr && !full;
  wire pop   = !empty && (st == S_IDLE) && !wpend;
  wire [13:0] h_addr = q_addr[rp];
  wire [31:0] h_data = q_data[rp];
  wire [CNT_W-1:0] free_cnt = DEPTH_C - used;
  wire busy = !empty || (st != S_IDLE) || wpend;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= bus_addr;
      q_data[wp] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (push) wp <= wp + PTR_W'(1);
      if (pop)  rp <= rp + PTR_W'(1);
      used <= used + CNT_W'(push) - CNT_W'(pop);
    end
  end

  logic [3:0]        op;
  logic              rep;
  logic [PIX_W-1:0]  color;
  logic [15:0]       fl, fr, fy, fh;
  logic              neg_x;
  logic [ADDR_W-1:0] step, src;
  logic [31:0]       dxb, dyl;
  logic [12:0]       pitch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= '0; rep <= 1'b0; color <= '0;
      fl <= '0; fr <= '0; fy <= '0; fh <= '0;
      neg_x <= 1'b0; step <= '0; src <= '0;
      dxb <= '0; dyl <= '0; pitch <= '0;
    end else if (pop) begin
      case (h_addr)
        A_CTRL, A_GO: begin op <= h_data[3:0]; rep <= h_data[19]; end
        A_COLOR: color <= h_data[PIX_W-1:0];
        A_FL:    fl    <= h_data[15:0];
        A_FR:    fr    <= h_data[15:0];
        A_FY:    fy    <= h_data[15:0];
        A_FH:    fh    <= h_data[15:0];
        A_SIGN:  neg_x <= h_data[0];
        A_STEP:  step  <= h_data[ADDR_W-1:0];
        A_SRC:   src   <= h_data[ADDR_W-1:0];
        A_DXB:   dxb   <= h_data;
        A_DYL:   dyl   <= h_data;
        A_PITCH: pitch <= h_data[12:0];
        default: ;
      endcase
    end
  end

  wire        is_fill = rep && (op == 4'h4);
  wire        is_copy = rep && (op == 4'h8);
  wire [15:0] cx_l    = dxb[15:0];
  wire [15:0] cx_r    = dxb[31:16];
  wire [16:0] fill_w  = (fr > fl) ? {1'b0, fr - fl} : 17'd0;
  wire [16:0] copy_w  = (cx_r >= cx_l) ? {1'b0, cx_r - cx_l} + 17'd1 : 17'd0;
  wire [16:0] l_wid   = is_copy ? copy_w : fill_w;
  wire [15:0] l_rows  = is_copy ? dyl[15:0] : fh;
  wire [15:0] l_y     = is_copy ? dyl[31:16] : fy;
  wire [15:0] l_x     = is_copy ? (neg_x ? cx_r : cx_l) : fl;
  wire [28:0] prod    = 29'(l_y) * 29'(pitch);
  wire [ADDR_W-1:0] l_dst = prod[ADDR_W-1:0] + ADDR_W'(l_x);

  logic              mode_copy;
  logic [16:0]       row_w, xcnt;
  logic [15:0]       ycnt;
  logic [ADDR_W-1:0] rstep, cur_dst, row_dst, cur_src, row_src, wdst;

  wire [ADDR_W-1:0] pstep = (mode_copy && neg_x) ? {ADDR_W{1'b1}} : ADDR_W'(1);
  wire run = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_copy <= 1'b0;
      row_w <= '0; xcnt <= '0; ycnt <= '0; rstep <= '0;
      cur_dst <= '0; row_dst <= '0; cur_src <= '0; row_src <= '0;
      wpend <= 1'b0; wdst <= '0;
    end else begin
      wpend <= run && mode_copy;
      wdst  <= cur_dst;
      case (st)
        S_IDLE: if (pop && h_addr == A_GO) st <= S_LAUNCH;
        S_LAUNCH: begin
          if ((is_fill || is_copy) && l_wid != 17'd0 && l_rows != 16'd0) begin
            st        <= S_RUN;
            mode_copy <= is_copy;
            row_w     <= l_wid;
            xcnt      <= l_wid;
            ycnt      <= l_rows;
            rstep     <= is_copy ? step : ADDR_W'(pitch);
            cur_dst   <= l_dst;
            row_dst   <= l_dst;
            cur_src   <= src;
            row_src   <= src;
          end else begin
            st <= S_IDLE;
          end
        end
        S_RUN: begin
          if (xcnt == 17'd1) begin
            if (ycnt == 16'd1) begin
              st <= S_IDLE;
            end else begin
              ycnt    <= ycnt - 16'd1;
              xcnt    <= row_w;
              row_dst <= row_dst + rstep;
              cur_dst <= row_dst + rstep;
              row_src <= row_src + rstep;
              cur_src <= row_src + rstep;
            end
          end else begin
            xcnt    <= xcnt - 17'd1;
            cur_dst <= cur_dst + pstep;
            cur_src <= cur_src + pstep;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = run && mode_copy;
  assign mem_rd_addr = cur_src;
  assign mem_wr_en   = wpend || (run && !mode_copy);
  assign mem_wr_addr = wpend ? wdst : cur_dst;
  assign mem_wr_data = wpend ? mem_rd_data : color;

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = {15'd0, busy, 16'd0};
      A_FREE:  bus_rdata = 32'(free_cnt);
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module blit2d_engine_chk #(
  parameter int PIX_W = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [PIX_W-1:0] mem_rd_data,
  input logic [PIX_W-1:0] mem_wr_data,
  input logic [CNT_W-1:0] free_cnt
);
  p_free_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(DEPTH));

  p_free_moves_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (free_cnt == $past(free_cnt)) || (free_cnt == $past(free_cnt) + 1'b1)
             || (free_cnt + 1'b1 == $past(free_cnt)));

  p_mem_only_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> busy);

  p_read_then_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  p_write_carries_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_data == mem_rd_data));
endmodule

bind blit2d_engine blit2d_engine_chk #(.PIX_W(PIX_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data), .free_cnt(free_cnt)
);

// File: tb/blit2d_engine_tb.sv
module blit2d_engine_tb;
  localparam int AW = 12;
  localparam int PW = 32;
  localparam int DEPTH = 8;
  localparam int MEMN = 1 << AW;
  localparam int P = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [PW-1:0] mem_rd_data, mem_wr_data;

  always #5 clk = ~clk;

  blit2d_engine #(.ADDR_W(AW), .PIX_W(PW), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hA000_0000 + 32'(i * 5);
  endfunction

  logic [31:0] mem [MEMN];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= pat(i);
      mem_rd_data <= '0;
    end else begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
      if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end
  end

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] shadow [MEMN];
  int exp_addr [$];
  logic [31:0] exp_data [$];
  string exp_tag [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_addr.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R2/R5/R6 unexpected write actual=%h:%h expected=none", mem_wr_addr, mem_wr_data);
      end else begin
        int a; logic [31:0] d; string t;
        a = exp_addr.pop_front(); d = exp_data.pop_front(); t = exp_tag.pop_front();
        check({t, " addr"}, 32'(mem_wr_addr), 32'(a));
        check({t, " data"}, mem_wr_data, d);
      end
    end
  end

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    s = 32'h1_0000;
    for (int i = 0; i < 3000 && s[16]; i++) rd(14'h200, s);
    check({tag, " busy clears"}, 32'(s[16]), 0);
    check({tag, " all writes seen"}, 32'(exp_addr.size()), 0);
  endtask

  task automatic push_fill(input int l, input int r, input int y, input int h,
                           input logic [31:0] c, input string tag);
    for (int row = y; row < y + h; row++)
      for (int x = l; x < r; x++) begin
        int a; a = (x + row * P) & (MEMN - 1);
        shadow[a] = c;
        exp_addr.push_back(a); exp_data.push_back(c); exp_tag.push_back(tag);
      end
  endtask

  task automatic prog_fill(input int l, input int r, input int y, input int h, input logic [31:0] c);
    wr(14'h004, c); wr(14'h008, 32'(l)); wr(14'h00C, 32'(r));
    wr(14'h010, 32'(y)); wr(14'h014, 32'(h));
  endtask

  task automatic blit(input int sx, input int sy, input int dx, input int dy,
                      input int w, input int h, input string tag);
    int sgn, ssy, ddy, wm, start, stp, drow0;
    sgn = 0; ssy = sy; ddy = dy; wm = w - 1;
    if (dy > sy && dy < sy + h) begin ssy += h - 1; ddy += h - 1; sgn |= 4; end
    start = sx + ssy * P;
    if (dx > sx && dx < sx + wm) begin start += wm; sgn |= 1; end
    stp = (sgn & 4) ? -P : P;
    drow0 = ddy * P + ((sgn & 1) ? dx + wm : dx);
    for (int r = 0; r < h; r++)
      for (int k = 0; k < w; k++) begin
        int s, d; logic [31:0] v;
        s = (start + r * stp + ((sgn & 1) ? -k : k)) & (MEMN - 1);
        d = (drow0 + r * stp + ((sgn & 1) ? -k : k)) & (MEMN - 1);
        v = shadow[s]; shadow[d] = v;
        exp_addr.push_back(d); exp_data.push_back(v); exp_tag.push_back(tag);
      end
    wr(14'h018, 32'(sgn)); wr(14'h01C, 32'(stp)); wr(14'h020, 32'(start));
    wr(14'h028, (32'(dx + wm) << 16) | 32'(dx)); wr(14'h02C, (32'(ddy) << 16) | 32'(h));
    wr(14'h100, 32'h000C_4008);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < MEMN; i++) shadow[i] = pat(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(14'h200, s); check("R1 busy after reset", 32'(s[16]), 0);
    rd(14'h204, s); check("R1 free after reset", s & 32'hFF, DEPTH);

    // R10: bit 13 of pitch is discarded, effective pitch 64
    wr(14'h030, 32'h0000_2040);
    prog_fill(2, 6, 3, 3, 32'h1111_1111);
    push_fill(2, 6, 3, 3, 32'h1111_1111, "R5 R10 fill");
    wr(14'h100, 32'h0008_0004);
    rd(14'h200, s); check("R3 busy after start", 32'(s[16]), 1);
    wait_idle("R5 fill");

    prog_fill(8, 9, 1, 1, 32'h2222_2222);
    wr(14'h000, 32'h0008_0004);
    repeat (20) @(negedge clk);
    wait_idle("R2 plain control no start");

    wr(14'h100, 32'h0000_0004);
    repeat (20) @(negedge clk);
    wait_idle("R2 no replace bit");

    prog_fill(5, 5, 1, 4, 32'h3333_3333);
    wr(14'h100, 32'h0008_0004);
    wait_idle("R5 empty width");
    prog_fill(5, 9, 1, 0, 32'h3333_3333);
    wr(14'h100, 32'h0008_0004);
    wait_idle("R5 zero rows");

    blit(2, 3, 10, 20, 4, 3, "R6 R8 copy disjoint");
    wait_idle("R6 copy");
    blit(10, 20, 12, 20, 6, 3, "R7 R9 copy rightward overlap");
    wait_idle("R7 copy");
    blit(10, 20, 10, 22, 6, 4, "R8 R9 copy downward overlap");
    wait_idle("R8 copy");
    blit(30, 5, 32, 6, 5, 4, "R7 R8 R9 copy diagonal overlap");
    wait_idle("R9 copy");
    blit(2, 3, 40, 40, 4, 0, "R6 zero rows");
    wait_idle("R6 zero rows");

    prog_fill(0, 16, 40, 16, 32'h4444_4444);
    push_fill(0, 16, 40, 16, 32'h4444_4444, "R4 long fill");
    wr(14'h100, 32'h0008_0004);
    push_fill(20, 24, 2, 2, 32'h5555_5555, "R4 queued fill");
    prog_fill(20, 24, 2, 2, 32'h5555_5555);
    wr(14'h100, 32'h0008_0004);
    wr(14'h030, 32'h0000_0040);
    rd(14'h204, s); check("R4 free after 7 queued", s & 32'hFF, 1);
    wr(14'h030, 32'h0000_0040);
    rd(14'h204, s); check("R4 free when full", s & 32'hFF, 0);
    rd(14'h200, s); check("R3 busy while queue full", 32'(s[16]), 1);
    wr(14'h004, 32'h6666_6666);
    rd(14'h204, s); check("R4 dropped write keeps full", s & 32'hFF, 0);
    wait_idle("R4 queue");
    rd(14'h204, s); check("R4 free after drain", s & 32'hFF, DEPTH);

    for (int i = 0; i < MEMN; i++)
      if (mem[i] !== shadow[i]) check("R9 final memory image", mem[i], shadow[i]);
    check("R9 memory image compared", 1, 1);
    finish_up();
  end
endmodule